// File: doc/BRIEF.md
# Reloading Baud Rate Downcounter

This block produces the bit-timing tick for a serial port. A host programs a 16-bit divisor as two byte registers (upper and lower byte) through a plain write port. A down-counter on the system clock starts at that divisor and steps down by one per clock. When it reaches one, the next clock loads the divisor again and raises a one-clock tick. The tick therefore repeats every *divisor* clocks. A divisor of zero stops the ticks.

Any write to a divisor byte restarts the counter. The counter loads the new combined value on the clock after the write, so a rate change does not wait for the old count to run out. Reset returns both bytes to a parameter default, holds the counter at that value and keeps the tick low.

Top module: `baud_downcount`

## Requirements
- R1: While `rstN` is low and after it is released, both divisor bytes equal the `RESET_DIV` default (0000h), and `baudTick` stays low. With that default, no tick appears until a write.
- R2: A write takes effect when `wrEn` is high at a rising clock edge. `wrAddr` = 1 writes the upper byte and `wrAddr` = 0 writes the lower byte. The divisor is {upper, lower}.
- R3: While the count is above one and no write is pending, the count falls by exactly one on each rising clock edge.
- R4: On the edge after the count equals one, the counter reloads the divisor and `baudTick` goes high for that clock.
- R5: For a divisor D of 2 or more, `baudTick` is high for one clock and ticks repeat every D clocks.
- R6: With a divisor of 0000h, `baudTick` never goes high.
- R7: With a divisor of 0001h, `baudTick` is high on every clock.
- R8: If the last divisor write is sampled at edge W, the counter holds the new divisor after edge W+1. The first tick then follows at edge W+1+D, whatever count was in progress.
- R9: Writing one byte leaves the other byte unchanged, and the new period uses the retained byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Divisor byte write strobe |
| wrAddr | input | 1 | Byte select: 1 upper, 0 lower |
| wrData | input | 8 | Byte to write |
| baudTick | output | 1 | End-of-count pulse, one clock wide |

## Verification
The assertions assume that `wrEn`, `wrAddr` and `wrData` carry known values at every rising edge after reset. They also assume that `wrAddr` always names an existing byte lane. The count and reload checks compare against the divisor value seen one cycle earlier, so the checks still hold when a write lands on the same edge as a reload. The stimulus meets these assumptions by driving every input to a defined value from the first instant. It changes inputs only on the falling edge, and it writes only the two valid byte addresses.

// File: rtl/baud_downcount_pkg.sv
package baud_downcount_pkg;

  // Strobes from control to datapath, one decision per clock.
  typedef struct packed {
    logic write;      // store wrData into the addressed byte lane
    logic loadCount;  // counter takes the divisor value
    logic decCount;   // counter steps down by one
    logic clearCount; // counter forced to zero (divisor is zero)
    logic pulse;      // end-of-count tick for the next clock
  } brgStrobe_t;

endpackage

// File: rtl/baud_downcount_ctrl.sv
module baud_downcount_ctrl
  import baud_downcount_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       cntIsOne,
  input  logic       cntIsZero,
  input  logic       divIsZero,
  output brgStrobe_t strb
);

  // Set by any divisor write; forces a load on the following edge.
  logic loadReq;

  always_ff @(posedge clk) begin
    if (!rstN) loadReq <= 1'b0;
    else       loadReq <= wrEn;
  end

  always_comb begin
    strb       = '0;
    strb.write = wrEn;
    if (loadReq) begin
      strb.loadCount = 1'b1;
    end else if (divIsZero) begin
      strb.clearCount = 1'b1;
    end else if (cntIsOne) begin
      strb.loadCount = 1'b1;
      strb.pulse     = 1'b1;
    end else if (cntIsZero) begin
      strb.loadCount = 1'b1;
    end else begin
      strb.decCount = 1'b1;
    end
  end

  AST_WRITE_ARMS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> strb.loadCount && !strb.pulse); // R8

endmodule

// File: rtl/baud_downcount_dp.sv
module baud_downcount_dp
  import baud_downcount_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_DIV = '0,
  localparam int NUM_BYTES = CNT_W / 8,
  localparam int ADDR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  brgStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              cntIsOne,
  output logic              cntIsZero,
  output logic              divIsZero,
  output logic              baudTick
);

  logic [NUM_BYTES-1:0][7:0] divLatch;
  logic [CNT_W-1:0]          divisor;
  logic [CNT_W-1:0]          count;

  // One latch per byte lane; the highest lane is the upper byte.
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)
        divLatch[b] <= RESET_DIV[b*8 +: 8];
      else if (strb.write && (wrAddr == ADDR_W'(b)))
        divLatch[b] <= wrData;
    end
  end

  assign divisor = divLatch;

  always_ff @(posedge clk) begin
    if (!rstN)                count <= RESET_DIV;
    else if (strb.loadCount)  count <= divisor;
    else if (strb.clearCount) count <= '0;
    else if (strb.decCount)   count <= count - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) baudTick <= 1'b0;
    else       baudTick <= strb.pulse;
  end

  assign cntIsOne  = (count == CNT_W'(1));
  assign cntIsZero = (count == '0);
  assign divIsZero = (divisor == '0);

  AST_TICK_AFTER_ONE: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> ($past(count) == CNT_W'(1)) && (count == $past(divisor))); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCount |=> count == $past(count) - CNT_W'(1)); // R3

  AST_LOAD_TAKES_DIV: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> count == $past(divisor)); // R8

  AST_SILENT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    divIsZero |=> !baudTick); // R6

endmodule

// File: rtl/baud_downcount.sv
module baud_downcount
  import baud_downcount_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_DIV = '0,
  localparam int NUM_BYTES = CNT_W / 8,
  localparam int ADDR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              baudTick
);

  brgStrobe_t strb;
  logic       cntIsOne;
  logic       cntIsZero;
  logic       divIsZero;

  baud_downcount_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .cntIsOne  (cntIsOne),
    .cntIsZero (cntIsZero),
    .divIsZero (divIsZero),
    .strb      (strb)
  );

  baud_downcount_dp #(
    .CNT_W     (CNT_W),
    .RESET_DIV (RESET_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .cntIsOne  (cntIsOne),
    .cntIsZero (cntIsZero),
    .divIsZero (divIsZero),
    .baudTick  (baudTick)
  );

endmodule

// File: tb/baud_downcount_tb.sv
module baud_downcount_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [0:0] wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       baudTick;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  baud_downcount u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .baudTick (baudTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // One byte write; returns on the falling edge after the sampling edge.
  task automatic writeByte(input bit hi, input logic [7:0] val);
    wrEn = 1'b1; wrAddr = hi; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeDiv(input logic [15:0] d);
    writeByte(1'b1, d[15:8]);
    writeByte(1'b0, d[7:0]);
  endtask

  // Falling edges until baudTick is seen high (limit+1 if never).
  task automatic waitTick(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baudTick && n <= limit);
  endtask

  task automatic periodRun(input int d, input int reps, input string req);
    int n;
    for (int i = 0; i < reps; i++) begin
      waitTick(d + 2, n);
      check(n == d, req, n, d);
    end
  endtask

  task automatic testReset();
    int highs = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (baudTick) highs++;
    end
    check(highs == 0, "R1 low in reset", highs, 0);
    rstN = 1'b1;
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (baudTick) highs++;
    end
    check(highs == 0, "R1 default divisor no tick", highs, 0);
  endtask

  task automatic testFive();
    int n;
    writeDiv(16'd5);
    waitTick(20, n);
    check(n == 6, "R8 first tick", n, 6);
    @(negedge clk);
    check(baudTick == 1'b0, "R5 one clock wide", baudTick, 0);
    waitTick(10, n);
    check(n == 4, "R5 period 5", n + 1, 5);
    periodRun(5, 3, "R4 reload period 5");
  endtask

  task automatic testOne();
    int n;
    int highs = 0;
    writeDiv(16'd1);
    waitTick(10, n);
    check(n == 2, "R7 first tick", n, 2);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (baudTick) highs++;
    end
    check(highs == 12, "R7 every clock", highs, 12);
  endtask

  task automatic testByteOrder();
    int n;
    writeDiv(16'h0103);
    waitTick(400, n);
    check(n == 260, "R2 upper byte first tick", n, 260);
    periodRun(259, 2, "R3 period 259");
  endtask

  task automatic testLowOnly();
    int n;
    writeByte(1'b0, 8'h02);
    waitTick(400, n);
    check(n == 259, "R9 upper byte kept", n, 259);
    periodRun(258, 1, "R9 period 258");
  endtask

  task automatic testMidChange();
    int n;
    writeDiv(16'd300);
    repeat (50) @(negedge clk);
    writeDiv(16'd7);
    waitTick(400, n);
    check(n == 8, "R8 restart mid count", n, 8);
    periodRun(7, 2, "R8 new period 7");
  endtask

  task automatic testZero();
    int n;
    writeDiv(16'd0);
    waitTick(600, n);
    check(n == 601, "R6 zero divisor silent", n, 601);
  endtask

  task automatic testResetMid();
    int n;
    writeDiv(16'd3);
    waitTick(10, n);
    check(n == 4, "R5 divisor 3 first tick", n, 4);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(baudTick == 1'b0, "R1 reset clears tick", baudTick, 0);
    rstN = 1'b1;
    waitTick(100, n);
    check(n == 101, "R1 latches back to default", n, 101);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    testReset();
    testFive();
    testOne();
    testByteOrder();
    testLowOnly();
    testMidChange();
    testZero();
    testResetMid();
    finishRun();
  end

endmodule